// File: doc/BRIEF.md
# PS/2 Controller Host Command Decoder

This block is the host-side register front end of a keyboard/mouse controller. A single byte-wide write/read bus with one select bit addresses two ports: select 0 is the data port and select 1 is the command/status port. The block holds an 8-bit mode byte and a status byte. It decodes command bytes into mode-bit updates, reply bytes, or an armed state that decides where the next data-port byte goes. Reply bytes are handed to a separate reply slot. Bytes bound for the keyboard, the mouse or the output-port logic leave on their own one-cycle valid/data strobes.

The decoder is a state machine. Its states are `ST_IDLE` (nothing armed), `ST_MODE` (the next data byte becomes the mode byte), `ST_OPORT` (the next data byte goes to the output-port logic), `ST_KOBF` (the next data byte is replied as keyboard data), `ST_AOBF` (the next data byte is replied as mouse data) and `ST_AFWD` (the next data byte is forwarded to the mouse). Command 0x60 moves it to `ST_MODE`, 0xD1 to `ST_OPORT`, 0xD2 to `ST_KOBF`, 0xD3 to `ST_AOBF` and 0xD4 to `ST_AFWD`. This happens from any state. Every data-port write returns the machine to `ST_IDLE`. Commands that do not arm leave the state unchanged.

All effects are registered. A write at clock edge N shows up on the strobes and on the mode output after edge N, and each strobe lasts one cycle.

Top module: `kbc_host_decoder`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, no command is armed and every strobe output is low.
- R2: When `bus_rd` and `bus_sel` are both high, `bus_rdata` carries the status byte combinationally; otherwise it is 0x00. A read changes no state.
- R3: Command 0x20 replies the mode byte as it stood when the command was written, with `reply_aux` low.
- R4: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no strobe and arm the decoder for the next data write. A later arming command replaces the armed one. A non-arming command leaves the armed one in place.
- R5: A data write while armed by 0x60 replaces the whole mode byte. `xlate_en` always equals mode bit 6.
- R6: A data write while armed by 0xD2 replies that byte with `reply_aux` low. While armed by 0xD3 it replies that byte with `reply_aux` high.
- R7: A data write while armed by 0xD4 presents the byte on `aux_tx_valid`/`aux_tx_data` and clears mode bit 5.
- R8: A data write with nothing armed presents the byte on `kbd_tx_valid`/`kbd_tx_data` and clears mode bit 4.
- R9: A data write while armed by 0xD1 presents the byte on `oport_valid`/`oport_data`.
- R10: Every data-port write leaves the decoder unarmed.
- R11: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00. Command 0xC0 replies 0x80. All of these replies have `reply_aux` low, and status bit 2 stays set until reset.
- R12: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. None of these four commands produces a reply.
- R13: Any other command byte raises `cmd_err` for one cycle and changes neither the mode, the status nor the armed state.
- R14: Each strobe (`reply_valid`, `kbd_tx_valid`, `aux_tx_valid`, `oport_valid`, `cmd_err`) is high for exactly the one cycle after the write that caused it. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | 0 = data port, 1 = command/status port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Status byte during a status-port read, else 0 |
| mode_o | output | 8 | Current mode byte |
| xlate_en | output | 1 | Scan-code translation enable (mode bit 6) |
| reply_valid | output | 1 | Reply byte strobe toward the reply slot |
| reply_data | output | 8 | Reply byte |
| reply_aux | output | 1 | Reply is tagged as mouse data |
| kbd_tx_valid | output | 1 | Byte forwarded to the keyboard side |
| kbd_tx_data | output | 8 | Keyboard-bound byte |
| aux_tx_valid | output | 1 | Byte forwarded to the mouse side |
| aux_tx_data | output | 8 | Mouse-bound byte |
| oport_valid | output | 1 | Byte destined for the output-port logic |
| oport_data | output | 8 | Output-port byte |
| cmd_err | output | 1 | Unrecognised command strobe |

## Verification
The assertions assume that `bus_wr` carries at most one byte per cycle and that the write inputs are stable around the sampling edge. They also assume that a reset is held for at least one clock before the first write. The stimulus drives every input on the falling edge, issues one write per task call with its strobe dropped a cycle later, and holds reset for several cycles. The random phase draws command bytes from both the defined list and arbitrary values, so the stability property on unrecognised commands is reached from many mode values and armed states.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;

    // mode byte bit positions that neighbours decode
    localparam int MB_KBD_OFF = 4;
    localparam int MB_AUX_OFF = 5;
    localparam int MB_XLATE   = 6;
    // status bit set by the self-test command
    localparam int SB_SELFOK  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_OPORT,
        ST_KOBF,
        ST_AOBF,
        ST_AFWD
    } kbc_state_t;

    typedef struct packed {
        logic              known;
        logic              arm;
        kbc_state_t        arm_st;
        logic              reply;
        logic              reply_mode;
        logic [BYTE_W-1:0] reply_byte;
        logic [BYTE_W-1:0] set_mask;
        logic [BYTE_W-1:0] clr_mask;
        logic              selfok;
    } kbc_cmd_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output kbc_cmd_t          dec
);

    localparam logic [BYTE_W-1:0] BIT_KBD = BYTE_W'(1) << MB_KBD_OFF;
    localparam logic [BYTE_W-1:0] BIT_AUX = BYTE_W'(1) << MB_AUX_OFF;

    always_comb begin
        dec            = '0;
        dec.arm_st     = ST_IDLE;
        dec.known      = 1'b1;
        case (code)
            8'h20: begin dec.reply = 1'b1; dec.reply_mode = 1'b1; end
            8'h60: begin dec.arm = 1'b1; dec.arm_st = ST_MODE;  end
            8'hD1: begin dec.arm = 1'b1; dec.arm_st = ST_OPORT; end
            8'hD2: begin dec.arm = 1'b1; dec.arm_st = ST_KOBF;  end
            8'hD3: begin dec.arm = 1'b1; dec.arm_st = ST_AOBF;  end
            8'hD4: begin dec.arm = 1'b1; dec.arm_st = ST_AFWD;  end
            8'hAA: begin
                dec.reply      = 1'b1;
                dec.reply_byte = 8'h55;
                dec.selfok     = 1'b1;
            end
            8'hA9, 8'hAB: begin dec.reply = 1'b1; dec.reply_byte = 8'h00; end
            8'hC0:        begin dec.reply = 1'b1; dec.reply_byte = 8'h80; end
            8'hA7: dec.set_mask = BIT_AUX;
            8'hA8: dec.clr_mask = BIT_AUX;
            8'hAD: dec.set_mask = BIT_KBD;
            8'hAE: dec.clr_mask = BIT_KBD;
            default: dec.known = 1'b0;
        endcase
    end

endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_RST = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [BYTE_W-1:0] mode_wdata,
    input  logic [BYTE_W-1:0] set_mask,
    input  logic [BYTE_W-1:0] clr_mask,
    input  logic              selfok_set,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] stat_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            stat_q <= STAT_RST;
        end else begin
            if (mode_load) begin
                mode_q <= mode_wdata;
            end else begin
                mode_q <= (mode_q | set_mask) & ~clr_mask;
            end
            if (selfok_set) begin
                stat_q[SB_SELFOK] <= 1'b1;
            end
        end
    end

    // R11
    selfok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[SB_SELFOK] |=> stat_q[SB_SELFOK]);

endmodule

// File: rtl/kbc_host_decoder.sv
module kbc_host_decoder
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_RST = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] mode_o,
    output logic              xlate_en,
    output logic              reply_valid,
    output logic [BYTE_W-1:0] reply_data,
    output logic              reply_aux,
    output logic              kbd_tx_valid,
    output logic [BYTE_W-1:0] kbd_tx_data,
    output logic              aux_tx_valid,
    output logic [BYTE_W-1:0] aux_tx_data,
    output logic              oport_valid,
    output logic [BYTE_W-1:0] oport_data,
    output logic              cmd_err
);

    localparam logic [BYTE_W-1:0] BIT_KBD = BYTE_W'(1) << MB_KBD_OFF;
    localparam logic [BYTE_W-1:0] BIT_AUX = BYTE_W'(1) << MB_AUX_OFF;

    kbc_state_t        state_q, state_d;
    kbc_cmd_t          dec;
    logic [BYTE_W-1:0] mode_q, stat_q;

    logic              mode_load;
    logic [BYTE_W-1:0] set_mask, clr_mask;
    logic              selfok_set;

    logic              rep_v_d, rep_aux_d, kbd_v_d, aux_v_d, op_v_d, err_d;
    logic [BYTE_W-1:0] rep_d;

    wire cmd_wr  = bus_wr &  bus_sel;
    wire data_wr = bus_wr & ~bus_sel;

    kbc_cmd_decode u_dec (
        .code (bus_wdata),
        .dec  (dec)
    );

    kbc_ctrl_regs #(
        .MODE_RST (MODE_RST),
        .STAT_RST (STAT_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_load  (mode_load),
        .mode_wdata (bus_wdata),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .selfok_set (selfok_set),
        .mode_q     (mode_q),
        .stat_q     (stat_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and next-cycle effects
    always_comb begin
        state_d    = state_q;
        mode_load  = 1'b0;
        set_mask   = '0;
        clr_mask   = '0;
        selfok_set = 1'b0;
        rep_v_d    = 1'b0;
        rep_aux_d  = 1'b0;
        rep_d      = '0;
        kbd_v_d    = 1'b0;
        aux_v_d    = 1'b0;
        op_v_d     = 1'b0;
        err_d      = 1'b0;
        if (cmd_wr) begin
            if (dec.known) begin
                if (dec.arm) begin
                    state_d = dec.arm_st;
                end
                rep_v_d    = dec.reply;
                rep_d      = dec.reply_mode ? mode_q : dec.reply_byte;
                set_mask   = dec.set_mask;
                clr_mask   = dec.clr_mask;
                selfok_set = dec.selfok;
            end else begin
                err_d = 1'b1;
            end
        end else if (data_wr) begin
            state_d = ST_IDLE;
            unique case (state_q)
                ST_IDLE: begin
                    kbd_v_d  = 1'b1;
                    clr_mask = BIT_KBD;
                end
                ST_MODE:  mode_load = 1'b1;
                ST_OPORT: op_v_d    = 1'b1;
                ST_KOBF: begin
                    rep_v_d = 1'b1;
                    rep_d   = bus_wdata;
                end
                ST_AOBF: begin
                    rep_v_d   = 1'b1;
                    rep_aux_d = 1'b1;
                    rep_d     = bus_wdata;
                end
                ST_AFWD: begin
                    aux_v_d  = 1'b1;
                    clr_mask = BIT_AUX;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply_valid  <= 1'b0;
            reply_aux    <= 1'b0;
            reply_data   <= '0;
            kbd_tx_valid <= 1'b0;
            kbd_tx_data  <= '0;
            aux_tx_valid <= 1'b0;
            aux_tx_data  <= '0;
            oport_valid  <= 1'b0;
            oport_data   <= '0;
            cmd_err      <= 1'b0;
        end else begin
            reply_valid  <= rep_v_d;
            reply_aux    <= rep_aux_d;
            reply_data   <= rep_d;
            kbd_tx_valid <= kbd_v_d;
            kbd_tx_data  <= kbd_v_d ? bus_wdata : '0;
            aux_tx_valid <= aux_v_d;
            aux_tx_data  <= aux_v_d ? bus_wdata : '0;
            oport_valid  <= op_v_d;
            oport_data   <= op_v_d ? bus_wdata : '0;
            cmd_err      <= err_d;
        end
    end

    assign mode_o    = mode_q;
    assign xlate_en  = mode_q[MB_XLATE];
    assign bus_rdata = (bus_rd && bus_sel) ? stat_q : '0;

    // R10
    idle_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> state_q == ST_IDLE);

    // R14
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reply_valid, kbd_tx_valid, aux_tx_valid, oport_valid, cmd_err}));

    // R13
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (mode_o == $past(mode_o)) && (stat_q == $past(stat_q)));

    // R8
    kbd_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_tx_valid |-> !mode_o[MB_KBD_OFF]);

    // R7
    aux_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_tx_valid |-> !mode_o[MB_AUX_OFF]);

    // R14
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_tx_valid && !$past(data_wr)) |-> 1'b0);

endmodule

// File: tb/kbc_host_decoder_tb.sv
module kbc_host_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, mode_o, reply_data, kbd_tx_data, aux_tx_data, oport_data;
    logic       xlate_en, reply_valid, reply_aux, kbd_tx_valid, aux_tx_valid, oport_valid, cmd_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    kbc_host_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_o(mode_o), .xlate_en(xlate_en),
        .reply_valid(reply_valid), .reply_data(reply_data), .reply_aux(reply_aux),
        .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
        .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
        .oport_valid(oport_valid), .oport_data(oport_data), .cmd_err(cmd_err)
    );

    // behavioural reference model
    int m_mode, m_stat, m_armed;
    int m_rv, m_rd, m_ra, m_kv, m_kd, m_av, m_ad, m_ov, m_od, m_err;

    always @(posedge clk) begin
        m_rv = 0; m_ra = 0; m_kv = 0; m_av = 0; m_ov = 0; m_err = 0;
        if (!rst_n) begin
            m_mode = 8'h03; m_stat = 8'h18; m_armed = 0;
        end else if (bus_wr && bus_sel) begin
            case (int'(bus_wdata))
                'h20: begin m_rv = 1; m_rd = m_mode; end
                'h60, 'hD1, 'hD2, 'hD3, 'hD4: m_armed = int'(bus_wdata);
                'hAA: begin m_stat = m_stat | 4; m_rv = 1; m_rd = 'h55; end
                'hA9, 'hAB: begin m_rv = 1; m_rd = 0; end
                'hC0: begin m_rv = 1; m_rd = 'h80; end
                'hA7: m_mode = m_mode | 'h20;
                'hA8: m_mode = m_mode & 'hDF;
                'hAD: m_mode = m_mode | 'h10;
                'hAE: m_mode = m_mode & 'hEF;
                default: m_err = 1;
            endcase
        end else if (bus_wr) begin
            case (m_armed)
                'h60: m_mode = int'(bus_wdata);
                'hD1: begin m_ov = 1; m_od = int'(bus_wdata); end
                'hD2: begin m_rv = 1; m_rd = int'(bus_wdata); end
                'hD3: begin m_rv = 1; m_ra = 1; m_rd = int'(bus_wdata); end
                'hD4: begin m_av = 1; m_ad = int'(bus_wdata); m_mode = m_mode & 'hDF; end
                default: begin m_kv = 1; m_kd = int'(bus_wdata); m_mode = m_mode & 'hEF; end
            endcase
            m_armed = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison, sampled 2 ns before the rising edge
    always @(negedge clk) begin
        #8;
        if (rst_n && !done) begin
            chk("R5 mode", int'(mode_o), m_mode);
            chk("R5 xlate", int'(xlate_en), (m_mode >> 6) & 1);
            chk("R2 rdata", int'(bus_rdata), (bus_rd && bus_sel) ? m_stat : 0);
            chk("R14 reply_valid", int'(reply_valid), m_rv);
            if (m_rv != 0) begin
                chk("R6 reply_data", int'(reply_data), m_rd);
                chk("R6 reply_aux", int'(reply_aux), m_ra);
            end
            chk("R14 kbd_valid", int'(kbd_tx_valid), m_kv);
            if (m_kv != 0) chk("R8 kbd_data", int'(kbd_tx_data), m_kd);
            chk("R14 aux_valid", int'(aux_tx_valid), m_av);
            if (m_av != 0) chk("R7 aux_data", int'(aux_tx_data), m_ad);
            chk("R14 oport_valid", int'(oport_valid), m_ov);
            if (m_ov != 0) chk("R9 oport_data", int'(oport_data), m_od);
            chk("R13 cmd_err", int'(cmd_err), m_err);
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 mode", int'(mode_o), 'h03);
        chk("R1 strobes", int'({reply_valid, kbd_tx_valid, aux_tx_valid, oport_valid, cmd_err}), 0);
        // R2 status read, no side effect
        bus_rd = 1'b1; bus_sel = 1'b1; #2;
        chk("R2 R1 status", int'(bus_rdata), 'h18);
        @(negedge clk); bus_rd = 1'b0; bus_sel = 1'b0;
        chk("R2 mode unchanged", int'(mode_o), 'h03);
        // R3
        wr(1, 8'h20);
        chk("R3 reply", int'({reply_valid, reply_aux, reply_data}), {1'b1, 1'b0, 8'h03});
        // R4 R5
        wr(1, 8'h60);
        chk("R4 quiet", int'({reply_valid, kbd_tx_valid, aux_tx_valid, oport_valid, cmd_err}), 0);
        wr(0, 8'hC5);
        chk("R5 mode load", int'(mode_o), 'hC5);
        chk("R5 xlate", int'(xlate_en), 1);
        // R8 R10
        wr(1, 8'hAD);
        chk("R12 kbd off", int'(mode_o), 'hD5);
        wr(0, 8'h22);
        chk("R8 R10 kbd fwd", int'({kbd_tx_valid, kbd_tx_data}), {1'b1, 8'h22});
        chk("R8 bit4 clear", int'(mode_o), 'hC5);
        // R7
        wr(1, 8'hA7);
        chk("R12 aux off", int'(mode_o), 'hE5);
        wr(1, 8'hD4); wr(0, 8'h33);
        chk("R7 aux fwd", int'({aux_tx_valid, aux_tx_data}), {1'b1, 8'h33});
        chk("R7 bit5 clear", int'(mode_o), 'hC5);
        // R6
        wr(1, 8'hD2); wr(0, 8'h44);
        chk("R6 kbd reply", int'({reply_valid, reply_aux, reply_data}), {1'b1, 1'b0, 8'h44});
        wr(1, 8'hD3); wr(0, 8'h45);
        chk("R6 aux reply", int'({reply_valid, reply_aux, reply_data}), {1'b1, 1'b1, 8'h45});
        // R9
        wr(1, 8'hD1); wr(0, 8'h66);
        chk("R9 oport", int'({oport_valid, oport_data}), {1'b1, 8'h66});
        // R11
        wr(1, 8'hAA);
        chk("R11 selftest reply", int'(reply_data), 'h55);
        bus_rd = 1'b1; bus_sel = 1'b1; #2;
        chk("R11 status bit2", int'(bus_rdata), 'h1C);
        @(negedge clk); bus_rd = 1'b0; bus_sel = 1'b0;
        wr(1, 8'hA9); chk("R11 A9 reply", int'({reply_valid, reply_data}), {1'b1, 8'h00});
        wr(1, 8'hAB); chk("R11 AB reply", int'({reply_valid, reply_data}), {1'b1, 8'h00});
        wr(1, 8'hC0); chk("R11 C0 reply", int'({reply_valid, reply_data}), {1'b1, 8'h80});
        // R12
        wr(1, 8'hA7); wr(1, 8'hAD);
        wr(1, 8'hA8); chk("R12 A8", int'(mode_o), 'hD5);
        chk("R12 no reply", int'(reply_valid), 0);
        wr(1, 8'hAE); chk("R12 AE", int'(mode_o), 'hC5);
        // R13
        wr(1, 8'hD2);
        wr(1, 8'h00);
        chk("R13 err", int'(cmd_err), 1);
        chk("R13 mode kept", int'(mode_o), 'hC5);
        wr(0, 8'h70);
        chk("R13 armed kept", int'({reply_valid, reply_data}), {1'b1, 8'h70});
        // R4 replacement and retention
        wr(1, 8'hD2); wr(1, 8'hD3); wr(0, 8'h77);
        chk("R4 replaced", int'({reply_valid, reply_aux, reply_data}), {1'b1, 1'b1, 8'h77});
        wr(1, 8'hD2); wr(1, 8'hA7); wr(0, 8'h78);
        chk("R4 retained", int'({reply_valid, reply_aux, reply_data}), {1'b1, 1'b0, 8'h78});
        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] b;
            logic       s;
            int         pick;
            pick = int'($urandom_range(0, 15));
            s = $urandom_range(0, 1) == 1;
            case (pick)
                0: b = 8'h20;  1: b = 8'h60;  2: b = 8'hD1;  3: b = 8'hD2;
                4: b = 8'hD3;  5: b = 8'hD4;  6: b = 8'hAA;  7: b = 8'hA7;
                8: b = 8'hA8;  9: b = 8'hAD;  10: b = 8'hAE; 11: b = 8'hC0;
                default: b = 8'($urandom);
            endcase
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk); bus_rd = 1'b1; bus_sel = 1'b1;
                @(negedge clk); bus_rd = 1'b0; bus_sel = 1'b0;
            end
            wr(s, b);
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule